// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the state-machine controller of a multicycle processor core for a small load/store instruction subset. Every instruction is walked through a series of one-clock steps: fetch, decode, then whatever of execute, memory access and register write-back the instruction class needs. A branch, a jump or a trap takes 3 cycles. An ALU operation or a store takes 4. A load takes 5. In every state the controller drives the datapath's enables and mux selects. A small combinational decoder turns the ALU mode and the function field into a 3-bit ALU operation code.

The opcode and function inputs come from the datapath's instruction register. The opcode is read only in the decode state, so it may change in any other cycle. An opcode outside the supported set sends the controller into a trap state. That state captures the faulting PC (PC minus 4, computed by the ALU) into the exception-PC register. It also loads the cause register with code 0 and steers the PC to the fixed exception vector. All pins are plain control levels. The block has no data stream and no handshake, so it never applies back-pressure.

Top module: `mcc_top`

## Requirements
- R1: `rst_n` low (asynchronous, active low) forces the fetch state. While reset is held the outputs show the fetch pattern. The first cycle after release is a fetch cycle, even if reset arrived in the middle of an instruction.
- R2: The fetch state drives `mem_rd`=1, `instr_ld`=1, `addr_sel`=0 (PC address), `alu_a_sel`=0 (PC), `alu_b_sel`=1 (constant 4), `alu_mode`=00, `pc_wr`=1 and `pc_src`=0 (ALU result). Every other output is 0.
- R3: For every opcode, the cycle after fetch is decode. Decode drives `alu_a_sel`=0, `alu_b_sel`=3 (immediate shifted left by 2) and `alu_mode`=00 to form the branch target. All enables are 0.
- R4: A load (opcode 0x23) takes 5 cycles. After decode come three states. The address state has `alu_a_sel`=1 and `alu_b_sel`=2 (sign-extended immediate), with add. The read state has `mem_rd`=1 and `addr_sel`=1. The write-back state has `rf_wr`=1, `wb_sel`=1 (memory data) and `rf_dst`=0.
- R5: A store (opcode 0x2B) takes 4 cycles: the address state as in R4, then `mem_wr`=1 with `addr_sel`=1.
- R6: An ALU-register instruction (opcode 0x00) takes 4 cycles. The execute state has `alu_a_sel`=1, `alu_b_sel`=0 and `alu_mode`=10. The write-back state has `rf_wr`=1, `rf_dst`=1 and `wb_sel`=0.
- R7: A branch-if-equal (opcode 0x04) takes 3 cycles. Its compare state drives `alu_a_sel`=1, `alu_b_sel`=0, `alu_mode`=01, `pc_wr_cond`=1 and `pc_src`=1 (ALU output register), then returns to fetch.
- R8: A jump (opcode 0x02) takes 3 cycles. Its third state drives `pc_wr`=1 and `pc_src`=2 (jump address).
- R9: Any other opcode takes 3 cycles. The trap state drives `epc_ld`=1, `cause_ld`=1, `cause_code`=0, `alu_a_sel`=0, `alu_b_sel`=1, `alu_mode`=01, `pc_wr`=1 and `pc_src`=3 (exception vector), then returns to fetch.
- R10: `alu_func` is 010 (add) for mode 00 or 11, and 110 (subtract) for mode 01. For mode 10 it follows the function field: 0x20 gives 010, 0x22 gives 110, 0x24 gives 000 (and), 0x25 gives 001 (or) and 0x2A gives 111 (set-less-than). Any other function code gives 010.
- R11: A change of `opcode` after decode has no effect on the rest of the instruction's sequence.
- R12: `mem_rd` and `mem_wr` are never high together. At most one of `mem_wr`, `rf_wr`, `pc_wr_cond` and `epc_ld` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field from the instruction register |
| funct | input | 6 | Function field from the instruction register |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write when the ALU reports equality |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| wb_sel | output | 1 | Register write data: 0 ALU output register, 1 memory data |
| instr_ld | output | 1 | Instruction register load |
| pc_src | output | 2 | PC source: 0 ALU, 1 ALU output register, 2 jump, 3 vector |
| alu_mode | output | 2 | 00 add, 01 subtract, 10 by function field |
| alu_a_sel | output | 1 | ALU A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B: 0 register B, 1 four, 2 immediate, 3 immediate shifted by 2 |
| rf_wr | output | 1 | Register file write |
| rf_dst | output | 1 | Destination field: 0 rt, 1 rd |
| epc_ld | output | 1 | Exception-PC register load |
| cause_ld | output | 1 | Cause register load |
| cause_code | output | 1 | Cause value select |
| alu_func | output | 3 | Decoded ALU operation |

## Verification
The hardest case to reach from the ports is a trap or a reset that arrives part way through an instruction. The other is an opcode that changes after decode. The bench reaches these by holding an unsupported opcode into decode, by pulling reset low during a load's memory-read cycle, and by switching the opcode to the branch code mid-load. In each case it compares the whole output vector, cycle by cycle, against the expected state pattern. Cycle counts are measured as the distance between consecutive fetch patterns.

// File: rtl/mcc_pkg.sv
`timescale 1ns/1ps
package mcc_pkg;
  localparam int OP_W   = 6;
  localparam int FN_W   = 6;
  localparam int AF_W   = 3;
  localparam int PCS_W  = 2;
  localparam int SRCB_W = 2;
  localparam int MODE_W = 2;

  localparam logic [OP_W-1:0] OP_REG   = 6'h00;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OP_STORE = 6'h2B;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'h04;
  localparam logic [OP_W-1:0] OP_JUMP  = 6'h02;

  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

  localparam logic [AF_W-1:0] AF_AND = 3'b000;
  localparam logic [AF_W-1:0] AF_OR  = 3'b001;
  localparam logic [AF_W-1:0] AF_ADD = 3'b010;
  localparam logic [AF_W-1:0] AF_SUB = 3'b110;
  localparam logic [AF_W-1:0] AF_SLT = 3'b111;

  localparam logic [MODE_W-1:0] MODE_ADD = 2'b00;
  localparam logic [MODE_W-1:0] MODE_SUB = 2'b01;
  localparam logic [MODE_W-1:0] MODE_FN  = 2'b10;

  localparam logic [PCS_W-1:0] PCS_ALU  = 2'd0;
  localparam logic [PCS_W-1:0] PCS_OUTR = 2'd1;
  localparam logic [PCS_W-1:0] PCS_JMP  = 2'd2;
  localparam logic [PCS_W-1:0] PCS_VEC  = 2'd3;

  localparam logic [SRCB_W-1:0] SB_REG   = 2'd0;
  localparam logic [SRCB_W-1:0] SB_FOUR  = 2'd1;
  localparam logic [SRCB_W-1:0] SB_IMM   = 2'd2;
  localparam logic [SRCB_W-1:0] SB_IMMSH = 2'd3;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_LDADDR, ST_LDRD, ST_LDWB,
    ST_STADDR, ST_STWR, ST_REXE, ST_RWB, ST_BRANCH,
    ST_JUMP, ST_TRAP
  } state_t;

  typedef enum logic [2:0] {
    CL_REG, CL_LOAD, CL_STORE, CL_BRANCH, CL_JUMP, CL_BAD
  } iclass_t;

  typedef struct packed {
    logic              pc_wr;
    logic              pc_wr_cond;
    logic              addr_sel;
    logic              mem_rd;
    logic              mem_wr;
    logic              wb_sel;
    logic              instr_ld;
    logic [PCS_W-1:0]  pc_src;
    logic [MODE_W-1:0] alu_mode;
    logic              alu_a_sel;
    logic [SRCB_W-1:0] alu_b_sel;
    logic              rf_wr;
    logic              rf_dst;
    logic              epc_ld;
    logic              cause_ld;
    logic              cause_code;
  } ctl_t;
endpackage

// File: rtl/mcc_opclass.sv
`timescale 1ns/1ps
module mcc_opclass
  import mcc_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output iclass_t         iclass
);
  always_comb begin
    unique case (opcode)
      OP_REG:   iclass = CL_REG;
      OP_LOAD:  iclass = CL_LOAD;
      OP_STORE: iclass = CL_STORE;
      OP_BEQ:   iclass = CL_BRANCH;
      OP_JUMP:  iclass = CL_JUMP;
      default:  iclass = CL_BAD;
    endcase
  end
endmodule

// File: rtl/mcc_seq.sv
`timescale 1ns/1ps
module mcc_seq
  import mcc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  iclass_t iclass,
  output state_t  state
);
  state_t nxt;

  // The class is consulted only while decoding; every other state has a fixed successor.
  always_comb begin
    nxt = ST_FETCH;
    unique case (state)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        unique case (iclass)
          CL_REG:    nxt = ST_REXE;
          CL_LOAD:   nxt = ST_LDADDR;
          CL_STORE:  nxt = ST_STADDR;
          CL_BRANCH: nxt = ST_BRANCH;
          CL_JUMP:   nxt = ST_JUMP;
          default:   nxt = ST_TRAP;
        endcase
      end
      ST_LDADDR: nxt = ST_LDRD;
      ST_LDRD:   nxt = ST_LDWB;
      ST_STADDR: nxt = ST_STWR;
      ST_REXE:   nxt = ST_RWB;
      default:   nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FETCH;
    else        state <= nxt;
  end
endmodule

// File: rtl/mcc_outdec.sv
`timescale 1ns/1ps
module mcc_outdec
  import mcc_pkg::*;
(
  input  state_t state,
  output ctl_t   ctl
);
  always_comb begin
    ctl = '0;
    unique case (state)
      ST_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.instr_ld  = 1'b1;
        ctl.alu_b_sel = SB_FOUR;
        ctl.alu_mode  = MODE_ADD;
        ctl.pc_wr     = 1'b1;
        ctl.pc_src    = PCS_ALU;
      end
      ST_DECODE: begin
        ctl.alu_b_sel = SB_IMMSH;
        ctl.alu_mode  = MODE_ADD;
      end
      ST_LDADDR, ST_STADDR: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = SB_IMM;
        ctl.alu_mode  = MODE_ADD;
      end
      ST_LDRD: begin
        ctl.mem_rd   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_LDWB: begin
        ctl.rf_wr  = 1'b1;
        ctl.wb_sel = 1'b1;
      end
      ST_STWR: begin
        ctl.mem_wr   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_REXE: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = SB_REG;
        ctl.alu_mode  = MODE_FN;
      end
      ST_RWB: begin
        ctl.rf_wr  = 1'b1;
        ctl.rf_dst = 1'b1;
      end
      ST_BRANCH: begin
        ctl.alu_a_sel  = 1'b1;
        ctl.alu_b_sel  = SB_REG;
        ctl.alu_mode   = MODE_SUB;
        ctl.pc_wr_cond = 1'b1;
        ctl.pc_src     = PCS_OUTR;
      end
      ST_JUMP: begin
        ctl.pc_wr  = 1'b1;
        ctl.pc_src = PCS_JMP;
      end
      ST_TRAP: begin
        ctl.alu_b_sel  = SB_FOUR;
        ctl.alu_mode   = MODE_SUB;
        ctl.epc_ld     = 1'b1;
        ctl.cause_ld   = 1'b1;
        ctl.cause_code = 1'b0;
        ctl.pc_wr      = 1'b1;
        ctl.pc_src     = PCS_VEC;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mcc_aludec.sv
`timescale 1ns/1ps
module mcc_aludec
  import mcc_pkg::*;
(
  input  logic [MODE_W-1:0] alu_mode,
  input  logic [FN_W-1:0]   funct,
  output logic [AF_W-1:0]   alu_func
);
  always_comb begin
    alu_func = AF_ADD;
    if (alu_mode == MODE_SUB) begin
      alu_func = AF_SUB;
    end else if (alu_mode == MODE_FN) begin
      unique case (funct)
        FN_ADD:  alu_func = AF_ADD;
        FN_SUB:  alu_func = AF_SUB;
        FN_AND:  alu_func = AF_AND;
        FN_OR:   alu_func = AF_OR;
        FN_SLT:  alu_func = AF_SLT;
        default: alu_func = AF_ADD;
      endcase
    end
  end
endmodule

// File: rtl/mcc_top.sv
`timescale 1ns/1ps
module mcc_top
  import mcc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  opcode,
  input  logic [5:0]  funct,
  output logic        pc_wr,
  output logic        pc_wr_cond,
  output logic        addr_sel,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic        wb_sel,
  output logic        instr_ld,
  output logic [1:0]  pc_src,
  output logic [1:0]  alu_mode,
  output logic        alu_a_sel,
  output logic [1:0]  alu_b_sel,
  output logic        rf_wr,
  output logic        rf_dst,
  output logic        epc_ld,
  output logic        cause_ld,
  output logic        cause_code,
  output logic [2:0]  alu_func
);
  iclass_t iclass;
  state_t  state;
  ctl_t    ctl;

  mcc_opclass u_class (.opcode(opcode), .iclass(iclass));
  mcc_seq     u_seq   (.clk(clk), .rst_n(rst_n), .iclass(iclass), .state(state));
  mcc_outdec  u_out   (.state(state), .ctl(ctl));
  mcc_aludec  u_alu   (.alu_mode(ctl.alu_mode), .funct(funct), .alu_func(alu_func));

  assign pc_wr      = ctl.pc_wr;
  assign pc_wr_cond = ctl.pc_wr_cond;
  assign addr_sel   = ctl.addr_sel;
  assign mem_rd     = ctl.mem_rd;
  assign mem_wr     = ctl.mem_wr;
  assign wb_sel     = ctl.wb_sel;
  assign instr_ld   = ctl.instr_ld;
  assign pc_src     = ctl.pc_src;
  assign alu_mode   = ctl.alu_mode;
  assign alu_a_sel  = ctl.alu_a_sel;
  assign alu_b_sel  = ctl.alu_b_sel;
  assign rf_wr      = ctl.rf_wr;
  assign rf_dst     = ctl.rf_dst;
  assign epc_ld     = ctl.epc_ld;
  assign cause_ld   = ctl.cause_ld;
  assign cause_code = ctl.cause_code;
endmodule

// File: rtl/mcc_chk.sv
`timescale 1ns/1ps
module mcc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pc_wr,
  input logic       pc_wr_cond,
  input logic       addr_sel,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       instr_ld,
  input logic [1:0] pc_src,
  input logic [1:0] alu_b_sel,
  input logic       rf_wr,
  input logic       epc_ld,
  input logic       cause_ld,
  input logic       cause_code
);
  assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (instr_ld && mem_rd && pc_wr));

  assert_fetch_pc_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    instr_ld |-> (mem_rd && !addr_sel && pc_wr && pc_src == 2'd0));

  assert_decode_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    instr_ld |=> (!instr_ld && !pc_wr && !mem_rd && alu_b_sel == 2'd3));

  assert_wb_is_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |=> instr_ld);

  assert_branch_is_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_cond |=> instr_ld);

  assert_trap_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    epc_ld |-> (cause_ld && !cause_code && pc_wr && pc_src == 2'd3));

  assert_trap_is_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    epc_ld |=> instr_ld);

  assert_mem_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_one_effect_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_wr, rf_wr, pc_wr_cond, epc_ld}));
endmodule

bind mcc_top mcc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
  .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .instr_ld(instr_ld),
  .pc_src(pc_src), .alu_b_sel(alu_b_sel), .rf_wr(rf_wr), .epc_ld(epc_ld),
  .cause_ld(cause_ld), .cause_code(cause_code)
);

// File: tb/tb_mcc_top.sv
`timescale 1ns/1ps
module tb_mcc_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'h00;
  logic [5:0] funct = 6'h20;
  logic       pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, wb_sel, instr_ld;
  logic [1:0] pc_src, alu_mode, alu_b_sel;
  logic       alu_a_sel, rf_wr, rf_dst, epc_ld, cause_ld, cause_code;
  logic [2:0] alu_func;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mcc_top dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .wb_sel(wb_sel), .instr_ld(instr_ld),
    .pc_src(pc_src), .alu_mode(alu_mode), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .rf_wr(rf_wr), .rf_dst(rf_dst), .epc_ld(epc_ld),
    .cause_ld(cause_ld), .cause_code(cause_code), .alu_func(alu_func)
  );

  // Field order: pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, wb_sel, instr_ld,
  // pc_src, alu_mode, alu_a_sel, alu_b_sel, rf_wr, rf_dst, epc_ld, cause_ld, cause_code
  function automatic logic [18:0] mk(input logic pw, pc, ad, mr, mw, ws, il,
                                     input logic [1:0] ps, am, input logic aa,
                                     input logic [1:0] ab, input logic rw, rd, el, cl);
    return {pw, pc, ad, mr, mw, ws, il, ps, am, aa, ab, rw, rd, el, cl, 1'b0};
  endfunction

  function automatic logic [18:0] observed();
    return {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, wb_sel, instr_ld,
            pc_src, alu_mode, alu_a_sel, alu_b_sel, rf_wr, rf_dst, epc_ld,
            cause_ld, cause_code};
  endfunction

  localparam logic [18:0] V_FETCH  = mk(1,0,0,1,0,0,1,2'd0,2'd0,0,2'd1,0,0,0,0);
  localparam logic [18:0] V_DECODE = mk(0,0,0,0,0,0,0,2'd0,2'd0,0,2'd3,0,0,0,0);
  localparam logic [18:0] V_ADDR   = mk(0,0,0,0,0,0,0,2'd0,2'd0,1,2'd2,0,0,0,0);
  localparam logic [18:0] V_LDRD   = mk(0,0,1,1,0,0,0,2'd0,2'd0,0,2'd0,0,0,0,0);
  localparam logic [18:0] V_LDWB   = mk(0,0,0,0,0,1,0,2'd0,2'd0,0,2'd0,1,0,0,0);
  localparam logic [18:0] V_STWR   = mk(0,0,1,0,1,0,0,2'd0,2'd0,0,2'd0,0,0,0,0);
  localparam logic [18:0] V_REXE   = mk(0,0,0,0,0,0,0,2'd0,2'd2,1,2'd0,0,0,0,0);
  localparam logic [18:0] V_RWB    = mk(0,0,0,0,0,0,0,2'd0,2'd0,0,2'd0,1,1,0,0);
  localparam logic [18:0] V_BRANCH = mk(0,1,0,0,0,0,0,2'd1,2'd1,1,2'd0,0,0,0,0);
  localparam logic [18:0] V_JUMP   = mk(1,0,0,0,0,0,0,2'd2,2'd0,0,2'd0,0,0,0,0);
  localparam logic [18:0] V_TRAP   = mk(1,0,0,0,0,0,0,2'd3,2'd1,0,2'd1,0,0,1,1);

  function automatic int n_cyc(input logic [5:0] op);
    case (op)
      6'h23:        return 5;
      6'h2B, 6'h00: return 4;
      default:      return 3;
    endcase
  endfunction

  function automatic string tag(input logic [5:0] op);
    case (op)
      6'h23:   return "R4";
      6'h2B:   return "R5";
      6'h00:   return "R6";
      6'h04:   return "R7";
      6'h02:   return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [18:0] exp_ctl(input logic [5:0] op, input int idx);
    if (idx == 0) return V_FETCH;
    if (idx == 1) return V_DECODE;
    case (op)
      6'h23:   return (idx == 2) ? V_ADDR : (idx == 3) ? V_LDRD : V_LDWB;
      6'h2B:   return (idx == 2) ? V_ADDR : V_STWR;
      6'h00:   return (idx == 2) ? V_REXE : V_RWB;
      6'h04:   return V_BRANCH;
      6'h02:   return V_JUMP;
      default: return V_TRAP;
    endcase
  endfunction

  function automatic logic [2:0] exp_func(input logic [5:0] fn);
    case (fn)
      6'h20:   return 3'b010;
      6'h22:   return 3'b110;
      6'h24:   return 3'b000;
      6'h25:   return 3'b001;
      6'h2A:   return 3'b111;
      default: return 3'b010;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  // Starts in a fetch cycle (sample point); walks the whole instruction.
  task automatic run_instr(input logic [5:0] op, input logic [5:0] fn,
                           input bit flip, input string extra);
    int n;
    n = n_cyc(op);
    opcode = op;
    funct = fn;
    for (int i = 0; i < n; i++) begin
      if (i == 0) check("R2", {extra, " fetch"}, observed(), V_FETCH);
      else if (i == 1) check("R3", {extra, " decode"}, observed(), V_DECODE);
      else check(flip ? "R11" : tag(op), {extra, " state"}, observed(), exp_ctl(op, i));
      if (i == 0) check("R10", "fetch add", alu_func, 3'b010);
      if (i == 2 && op == 6'h00) check("R10", "funct decode", alu_func, exp_func(fn));
      if (i == 2 && op == 6'h04) check("R10", "branch sub", alu_func, 3'b110);
      if (i == 2 && op != 6'h00 && op != 6'h04 && op != 6'h23 && op != 6'h2B && op != 6'h02)
        check("R10", "trap sub", alu_func, 3'b110);
      if (i >= 2 && flip) opcode = 6'h04;
      if (i == 1 && flip) begin
        step();
        opcode = 6'h04;
        check("R11", {extra, " addr"}, observed(), exp_ctl(op, 2));
        i++;
      end
      if (i < n - 1) begin
        if (!(flip && i == 2 && n > 3 && 0)) step();
      end
    end
    step();
    check(flip ? "R11" : tag(op), {extra, " cycle count"}, observed(), V_FETCH);
  endtask

  task automatic t_reset();
    check("R1", "fetch during reset", observed(), V_FETCH);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "fetch after release", observed(), V_FETCH);
  endtask

  task automatic t_reset_mid();
    opcode = 6'h23;
    step();
    step();
    step();
    check("R4", "load read before reset", observed(), V_LDRD);
    rst_n = 1'b0;
    #1;
    check("R1", "async reset mid-load", observed(), V_FETCH);
    step();
    check("R1", "reset held", observed(), V_FETCH);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    run_instr(6'h23, 6'h20, 1'b0, "after mid reset");
  endtask

  task automatic t_alu_modes();
    run_instr(6'h00, 6'h20, 1'b0, "reg add");
    run_instr(6'h00, 6'h22, 1'b0, "reg sub");
    run_instr(6'h00, 6'h24, 1'b0, "reg and");
    run_instr(6'h00, 6'h25, 1'b0, "reg or");
    run_instr(6'h00, 6'h2A, 1'b0, "reg slt");
    run_instr(6'h00, 6'h3F, 1'b0, "reg unknown funct");
  endtask

  initial begin : main
    #1;
    step();
    step();
    t_reset();
    run_instr(6'h23, 6'h00, 1'b0, "load");
    run_instr(6'h2B, 6'h00, 1'b0, "store");
    t_alu_modes();
    run_instr(6'h04, 6'h00, 1'b0, "branch");
    run_instr(6'h02, 6'h00, 1'b0, "jump");
    run_instr(6'h3F, 6'h00, 1'b0, "undefined 3F");
    run_instr(6'h01, 6'h00, 1'b0, "undefined 01");
    run_instr(6'h23, 6'h00, 1'b1, "load with opcode flip");
    run_instr(6'h2B, 6'h00, 1'b1, "store with opcode flip");
    run_instr(6'h00, 6'h25, 1'b1, "reg with opcode flip");
    // R12: mem_rd and mem_wr are never seen high together in a store's write cycle
    opcode = 6'h2B;
    step();
    step();
    step();
    check("R12", "store write excl", {31'd0, mem_rd & mem_wr}, 32'd0);
    step();
    t_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : watchdog
    wait (cyc >= 20000);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule